// File: doc/BRIEF.md
# Manchester Burst Word Receiver

This block recovers 16-bit words from short bursts on one serial line. Each burst is framed like an asynchronous character. A start bit and a stop bit, both coded as Manchester ones, enclose the data bits, which arrive most significant bit first. Between bursts the line rests high. Every bit carries a transition at its middle. Low-then-high means one and high-then-low means zero. The block is clocked at sixteen times the bit rate, so one clock is one sample tick.

The line first passes a two-flop synchroniser. A falling edge seen while hunting opens a start bit, which is confirmed by sampling it a quarter and three quarters of the way through the bit. Each data bit is decoded from the same two sample points. Every mid-bit transition pulls the tick counter back into phase, so a sender whose rate is off by more than ten percent is still followed. A data bit without a mid-bit transition, or a stop bit that is not a one, aborts the frame with a framing error. After such an error, and after reset, the receiver ignores the line until it has stayed high for three full bit periods. A good word is presented with a one-cycle strobe and held until the next word arrives. A word that completes while the previous one is still unacknowledged raises an overrun flag.

Top module: `manchester_word_rx`

## Requirements
- R1: While rst is high, and on the first cycles after it, rx_valid, frame_err and overrun are 0 and rx_data is all zeros.
- R2: A frame is a start bit, 16 data bits (most significant first) and a stop bit. Each bit lasts 16 ticks. A one is low for 8 ticks then high for 8, a zero is high then low, and start and stop are ones. A correct frame produces exactly one rx_valid pulse, one clock long, with the word on rx_data.
- R3: rx_data keeps the last delivered word unchanged until the next rx_valid pulse.
- R4: While hunting, a low pulse shorter than a quarter bit (4 ticks) is rejected as a false start: it produces neither a word nor an error, and a following frame decodes normally.
- R5: Mid-bit transitions re-phase the tick counter, so frames whose half-bits last 7 or 9 ticks instead of 8 decode correctly.
- R6: A data bit whose two half-bit samples are equal produces a one-cycle frame_err pulse and no rx_valid for that frame.
- R7: A stop bit that is not a Manchester one produces a one-cycle frame_err pulse and no rx_valid; frame_err and rx_valid are never high together.
- R8: After reset and after any framing error, falling edges are ignored until the line has stayed high for 48 consecutive ticks (three bit periods); a whole frame sent inside that window yields no output.
- R9: If a word is delivered while the previous word has not been acknowledged with rd_ack, overrun goes to 1 in the same cycle as that rx_valid, and the new word is still presented on rx_data.
- R10: overrun falls only in the cycle after rd_ack was high; words that are each acknowledged never set overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock at 16x the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_ack | input | 1 | Acknowledges the word currently presented |
| rx_data | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe when a new word is on rx_data |
| frame_err | output | 1 | One-cycle strobe when a frame is aborted |
| overrun | output | 1 | A word arrived before the previous one was acknowledged |

## Verification
The bench builds the block with its default values: 16-bit words, sixteen ticks per bit, a three-bit idle window and two synchroniser stages. With these values the 48-tick resync window, the quarter-bit glitch limit and the 7- and 9-tick half-bit senders can be driven within a few thousand clocks. Because the window is short, the bench can send a complete frame inside it right after reset and right after an aborted frame, and show that the frame is dropped. The same values let it cover both overrun orderings, with acknowledged and unacknowledged word pairs.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef enum logic [2:0] {
    ST_RESYNC,
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_t;
endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic fell,
  output logic toggled
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '1;
      last <= 1'b1;
    end else begin
      pipe <= {pipe[STAGES-2:0], din};
      last <= pipe[STAGES-1];
    end
  end

  assign dout    = pipe[STAGES-1];
  assign fell    = last & ~pipe[STAGES-1];
  assign toggled = last ^ pipe[STAGES-1];
endmodule

// File: rtl/mrx_idle_timer.sv
module mrx_idle_timer #(
  parameter int LIMIT = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic line,
  output logic idle_ok
);
  localparam int CNTW = $clog2(LIMIT + 1);
  logic [CNTW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0;
    end else if (!line) begin
      run <= '0;
    end else if (run != CNTW'(LIMIT)) begin
      run <= run + 1'b1;
    end
  end

  assign idle_ok = (run == CNTW'(LIMIT));
endmodule

// File: rtl/mrx_bit_engine.sv
module mrx_bit_engine
  import mrx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line,
  input  logic              fell,
  input  logic              toggled,
  input  logic              idle_ok,
  output logic              word_stb,
  output logic              err_stb,
  output logic [DATA_W-1:0] word
);
  localparam int HALF   = OVS / 2;
  localparam int QTR    = OVS / 4;
  localparam int EARLY  = QTR;
  localparam int LATE   = HALF + QTR;
  localparam int WIN_LO = HALF - QTR + 1;
  localparam int WIN_HI = HALF + QTR - 1;
  localparam int CW     = $clog2(OVS);
  localparam int BW     = $clog2(DATA_W + 1);

  rx_state_t         state;
  logic [CW-1:0]     tick;
  logic [BW-1:0]     nbits;
  logic              h1;
  logic [DATA_W-1:0] shreg;

  logic at_early, at_late, at_end, in_window, is_one;

  assign at_early  = (tick == CW'(EARLY));
  assign at_late   = (tick == CW'(LATE));
  assign at_end    = (tick == CW'(OVS - 1));
  assign in_window = (tick >= CW'(WIN_LO)) && (tick <= CW'(WIN_HI));
  assign is_one    = !h1 && line;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RESYNC;
      tick  <= '0;
      nbits <= '0;
      h1    <= 1'b1;
      shreg <= '0;
    end else begin
      case (state)
        ST_RESYNC: begin
          tick <= '0;
          if (idle_ok) state <= ST_HUNT;
        end
        ST_HUNT: begin
          tick  <= '0;
          nbits <= '0;
          if (fell) begin
            state <= ST_START;
            tick  <= CW'(1);
          end
        end
        default: begin
          if (toggled && in_window) tick <= CW'(HALF + 1);
          else if (at_end)          tick <= '0;
          else                      tick <= tick + 1'b1;

          if (at_early) h1 <= line;
          if (state == ST_START && at_early && line) state <= ST_HUNT;

          if (at_late) begin
            case (state)
              ST_START: if (!is_one) state <= ST_HUNT;
              ST_DATA: begin
                if (h1 == line) begin
                  state <= ST_RESYNC;
                end else begin
                  shreg <= {shreg[DATA_W-2:0], line};
                  nbits <= nbits + 1'b1;
                end
              end
              ST_STOP: state <= is_one ? ST_HUNT : ST_RESYNC;
              default: state <= ST_RESYNC;
            endcase
          end

          if (at_end) begin
            if (state == ST_START) state <= ST_DATA;
            else if (state == ST_DATA && nbits == BW'(DATA_W)) state <= ST_STOP;
          end

          if (idle_ok) state <= ST_HUNT;
        end
      endcase
    end
  end

  assign word_stb = (state == ST_STOP) && at_late && is_one;
  assign err_stb  = at_late && (((state == ST_DATA) && (h1 == line)) ||
                                ((state == ST_STOP) && !is_one));
  assign word     = shreg;
endmodule

// File: rtl/mrx_out_stage.sv
module mrx_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_stb,
  input  logic              err_stb,
  input  logic [DATA_W-1:0] word,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              frame_err,
  output logic              overrun
);
  logic pending;
  logic collide;

  assign collide = word_stb && pending && !rd_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
      pending   <= 1'b0;
    end else begin
      rx_valid  <= word_stb;
      frame_err <= err_stb;
      if (word_stb) rx_data <= word;

      if (word_stb)    pending <= 1'b1;
      else if (rd_ack) pending <= 1'b0;

      if (collide)     overrun <= 1'b1;
      else if (rd_ack) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/manchester_word_rx.sv
module manchester_word_rx #(
  parameter int DATA_W      = 16,
  parameter int OVS         = 16,
  parameter int IDLE_BITS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              frame_err,
  output logic              overrun
);
  localparam int IDLE_TICKS = OVS * IDLE_BITS;

  logic              line_s, line_fell, line_tog, idle_ok;
  logic              word_stb, err_stb;
  logic [DATA_W-1:0] word;

  mrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_line),
    .dout(line_s), .fell(line_fell), .toggled(line_tog)
  );

  mrx_idle_timer #(.LIMIT(IDLE_TICKS)) u_idle (
    .clk(clk), .rst(rst), .line(line_s), .idle_ok(idle_ok)
  );

  mrx_bit_engine #(.DATA_W(DATA_W), .OVS(OVS)) u_eng (
    .clk(clk), .rst(rst), .line(line_s), .fell(line_fell),
    .toggled(line_tog), .idle_ok(idle_ok),
    .word_stb(word_stb), .err_stb(err_stb), .word(word)
  );

  mrx_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .word_stb(word_stb), .err_stb(err_stb),
    .word(word), .rd_ack(rd_ack), .rx_data(rx_data),
    .rx_valid(rx_valid), .frame_err(frame_err), .overrun(overrun)
  );
endmodule

// File: rtl/mrx_checker.sv
module mrx_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_ack,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              frame_err,
  input logic              overrun
);
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_data));

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);

  assert_err_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(frame_err && rx_valid));

  assert_ovr_set_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> rx_valid);

  assert_ovr_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(overrun) |-> $past(rd_ack));
endmodule

bind manchester_word_rx mrx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd_ack(rd_ack), .rx_data(rx_data),
  .rx_valid(rx_valid), .frame_err(frame_err), .overrun(overrun)
);

// File: tb/tb_manchester_word_rx.sv
`timescale 1ns/1ps
module tb_manchester_word_rx;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_line = 1'b1;
  logic          manual_ack = 1'b0;
  logic          auto_ack = 1'b0;
  logic          rd_ack;
  logic [DW-1:0] rx_data;
  logic          rx_valid, frame_err, overrun;

  assign rd_ack = manual_ack | auto_ack;

  always #10 clk = ~clk;

  manchester_word_rx dut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .rd_ack(rd_ack),
    .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
    .overrun(overrun)
  );

  typedef struct {
    bit            is_err;
    logic [DW-1:0] word;
    string         req;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  int   events = 0;
  bit   ack_en = 1'b1;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic v, int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic man_bit(logic b, int half);
    drive(~b, half);
    drive(b, half);
  endtask

  // Driver: pushes the expected item, then sends the frame.
  task automatic send_frame(logic [DW-1:0] w, int half, int bad_idx,
                            bit stop_zero, bit expect_out, string req);
    exp_t e;
    if (expect_out) begin
      e.is_err = (bad_idx >= 0) || stop_zero;
      e.word   = w;
      e.req    = req;
      sb.push_back(e);
    end
    man_bit(1'b1, half);
    for (int i = DW - 1; i >= 0; i--) begin
      if (DW - 1 - i == bad_idx) begin
        drive(1'b1, 2 * half);
        return;
      end
      man_bit(w[i], half);
    end
    man_bit(stop_zero ? 1'b0 : 1'b1, half);
  endtask

  // Monitor: pops and compares each result the design produces.
  always @(negedge clk) begin : monitor
    exp_t e;
    auto_ack <= 1'b0;
    if (!rst && (rx_valid || frame_err)) begin
      events++;
      auto_ack <= ack_en && rx_valid;
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected output", {30'd0, rx_valid, frame_err}, 32'd0);
      end else begin
        e = sb.pop_front();
        if (e.is_err)
          check(frame_err && !rx_valid, e.req, "framing error strobe",
                {30'd0, rx_valid, frame_err}, 32'd1);
        else
          check(rx_valid && !frame_err && rx_data == e.word, e.req, "received word",
                {16'd0, rx_data}, {16'd0, e.word});
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int ev0;
    repeat (4) @(negedge clk);
    check(rx_valid == 0 && frame_err == 0 && overrun == 0 && rx_data == 0,
          "R1", "reset outputs", {13'd0, rx_valid, frame_err, overrun, rx_data}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(rx_valid == 0 && frame_err == 0 && overrun == 0 && rx_data == 0,
          "R1", "outputs after reset", {13'd0, rx_valid, frame_err, overrun, rx_data}, 32'd0);

    // R8: a frame right after reset falls inside the resync window.
    drive(1'b1, 5);
    send_frame(16'hC0DE, 8, -1, 1'b0, 1'b0, "R8");
    drive(1'b1, 60);
    check(events == 0, "R8", "frame ignored after reset", events, 0);

    // R2: nominal frames.
    send_frame(16'hA5C3, 8, -1, 1'b0, 1'b1, "R2"); drive(1'b1, 60);
    send_frame(16'h0000, 8, -1, 1'b0, 1'b1, "R2"); drive(1'b1, 60);
    send_frame(16'hFFFF, 8, -1, 1'b0, 1'b1, "R2"); drive(1'b1, 60);
    send_frame(16'h8001, 8, -1, 1'b0, 1'b1, "R2"); drive(1'b1, 100);
    check(rx_data == 16'h8001 && !rx_valid, "R3", "word held after strobe",
          {16'd0, rx_data}, 32'h8001);

    // R4: short low glitch while hunting.
    ev0 = events;
    drive(1'b0, 2);
    drive(1'b1, 60);
    check(events == ev0, "R4", "glitch produced no output", events, ev0);
    send_frame(16'h1234, 8, -1, 1'b0, 1'b1, "R4"); drive(1'b1, 60);

    // R5: slow and fast senders.
    send_frame(16'h6DB6, 9, -1, 1'b0, 1'b1, "R5"); drive(1'b1, 60);
    send_frame(16'h9249, 7, -1, 1'b0, 1'b1, "R5"); drive(1'b1, 60);

    // R6 then R8: bad data bit, then a frame inside the resync window.
    ev0 = events;
    send_frame(16'hF0F0, 8, 5, 1'b0, 1'b1, "R6");
    send_frame(16'h5555, 8, -1, 1'b0, 1'b0, "R8");
    drive(1'b1, 60);
    check(events == ev0 + 1, "R8", "frame after error ignored", events, ev0 + 1);
    send_frame(16'h3C3C, 8, -1, 1'b0, 1'b1, "R8"); drive(1'b1, 60);

    // R7: stop bit sent as a zero.
    send_frame(16'h0F0F, 8, -1, 1'b1, 1'b1, "R7"); drive(1'b1, 60);
    send_frame(16'h7E81, 8, -1, 1'b0, 1'b1, "R7"); drive(1'b1, 60);

    // R9: two words without acknowledge.
    ack_en = 1'b0;
    send_frame(16'hAAAA, 8, -1, 1'b0, 1'b1, "R9"); drive(1'b1, 60);
    check(overrun == 0, "R9", "no overrun after first word", {31'd0, overrun}, 32'd0);
    send_frame(16'h5A5A, 8, -1, 1'b0, 1'b1, "R9"); drive(1'b1, 60);
    check(overrun == 1 && rx_data == 16'h5A5A, "R9", "overrun with new word kept",
          {15'd0, overrun, rx_data}, 32'h15A5A);

    // R10: acknowledge clears it; acknowledged words do not set it.
    manual_ack = 1'b1;
    @(negedge clk);
    manual_ack = 1'b0;
    @(negedge clk);
    check(overrun == 0, "R10", "overrun cleared by ack", {31'd0, overrun}, 32'd0);
    ack_en = 1'b1;
    send_frame(16'h1111, 8, -1, 1'b0, 1'b1, "R10"); drive(1'b1, 60);
    send_frame(16'h2222, 8, -1, 1'b0, 1'b1, "R10"); drive(1'b1, 60);
    check(overrun == 0, "R10", "acknowledged words no overrun", {31'd0, overrun}, 32'd0);

    check(sb.size() == 0, "R2", "all expected results seen", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule